// File: doc/BRIEF.md
# Indexed Scatter Writer

The block takes a tile of up to `ROWS` x `COLS` signed source elements and a tile of unsigned indices, and writes the source values into an external table memory. In row mode, a single index picks the destination row for each whole source row. In element mode, each source element has its own index, which names a linear slot in the table. The table sits outside the block. The block reaches it through a write port and a read port with one cycle of latency. The read port is used only when an update has to combine the old table value with the source value.

A `start` pulse captures the configuration, the valid extents and both tiles. The block then works through the valid region one element at a time, in increasing row-major order, and raises a one-cycle `done` when it has finished. Each index first passes through a selectable out-of-range policy, which can leave it alone, drop the write, pin it to the last slot, or fold it by modulo. A selectable update policy then either stores the source value or merges it with the old value by add, signed maximum or signed minimum.

Top module: `idx_scatter`

## Requirements
- R1: After reset, `busy`, `done`, `wr_en` and `rd_en` are all low.
- R2: `start` is accepted only while `busy` is low. While the block is busy, `start` and any change on the tile or configuration inputs have no effect on the writes. `done` is high for exactly one cycle, in the cycle after the last element's write is presented, and `busy` is low in the cycle after that.
- R3: Row mode (`mode`=0): the index for source row r sits at `idx_tile[r*IW +: IW]`. Element (r,c) is written to address `slot*ROW_STRIDE + c`, where slot is that row's index after remapping.
- R4: Element mode (`mode`=1): the index for element (r,c) sits at `idx_tile[(r*COLS+c)*IW +: IW]`. The element is written to linear address slot. Source element (r,c) always sits at `src_tile[(r*COLS+c)*DW +: DW]`.
- R5: Elements are handled in increasing row-major order over the valid region. With plain store, a later element that targets the same address overwrites an earlier one.
- R6: Out-of-range policy 1 (skip): an index at or above capacity produces no write, and the table keeps its old value.
- R7: Out-of-range policy 2 (clamp): an index at or above capacity is replaced by capacity-1.
- R8: Out-of-range policy 3 (wrap): the index is replaced by index modulo capacity.
- R9: Capacity is `TBL_ROWS` in row mode and `TBL_ROWS*ROW_STRIDE` in element mode.
- R10: Update policies 1 (add), 2 (max) and 3 (min) read the destination through the read port. The merged value is written to the same address in the next cycle. With add, repeated destinations accumulate. Policy 0 (store) never reads.
- R11: Max and min compare the old and source values as signed two's-complement numbers.
- R12: `vld_rows` and `vld_cols` (each 1 up to the tile size) bound the walk. A 1x1 element-mode operation is accepted and produces a single write.
- R13: Out-of-range policy 0 uses the index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| mode | input | 1 | 0 = row addressing, 1 = element addressing |
| oob_pol | input | 2 | Out-of-range policy: 0 none, 1 skip, 2 clamp, 3 wrap |
| atom_op | input | 2 | Update policy: 0 store, 1 add, 2 max, 3 min |
| vld_rows | input | RW | Valid source rows |
| vld_cols | input | CW | Valid source columns |
| src_tile | input | ROWS*COLS*DW | Packed signed source elements |
| idx_tile | input | ROWS*COLS*IW | Packed unsigned indices |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_en | output | 1 | Table read request |
| rd_addr | output | AW | Table read address |
| rd_data | input | DW | Table read data, valid one cycle after `rd_en` |
| wr_en | output | 1 | Table write strobe |
| wr_addr | output | AW | Table write address |
| wr_data | output | DW | Table write data |

## Verification
The bench goes after the capacity edges in both modes. Index 6 must be dropped in row mode, while index 29 must still land in element mode. A design that used the wrong capacity would corrupt or skip the wrong slots. The bench also sends duplicate destinations under store and under add: a design that reordered the walk would leave the wrong winner, and one that used a stale read would lose part of the accumulated sum. Signed max and min runs use mixed-sign values, which an unsigned comparison gets wrong. The remaining cases are a 1x1 tile, a partial extent, and a second `start` pulse in mid-operation, which a design that restarts or relatches would reveal through extra or shifted writes.

// File: rtl/scatter_pkg.sv
package scatter_pkg;
  typedef enum logic {MODE_ROW = 1'b0, MODE_ELEM = 1'b1} mode_e;
  typedef enum logic [1:0] {OOB_NONE = 2'd0, OOB_SKIP = 2'd1, OOB_CLAMP = 2'd2, OOB_WRAP = 2'd3} oob_e;
  typedef enum logic [1:0] {ATOM_STORE = 2'd0, ATOM_ADD = 2'd1, ATOM_MAX = 2'd2, ATOM_MIN = 2'd3} atom_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ISSUE = 2'd1, ST_MERGE = 2'd2, ST_DONE = 2'd3} st_e;
endpackage

// File: rtl/scatter_walk.sv
module scatter_walk #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int RW = $clog2(ROWS + 1),
  localparam int CW = $clog2(COLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          active,
  input  logic [RW-1:0] n_rows,
  input  logic [CW-1:0] n_cols,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col,
  output logic          last
);
  logic row_end;
  logic col_end;

  assign row_end = (row == n_rows - RW'(1));
  assign col_end = (col == n_cols - CW'(1));
  assign last    = row_end && col_end;

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      row <= '0;
      col <= '0;
    end else if (step && !last) begin
      if (col_end) begin
        col <= '0;
        row <= row + RW'(1);
      end else begin
        col <= col + CW'(1);
      end
    end
  end

  AST_WALK_IN_EXTENT: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (row < n_rows) && (col < n_cols)); // R12
endmodule

// File: rtl/scatter_slot.sv
module scatter_slot
  import scatter_pkg::*;
#(
  parameter int IW = 8,
  parameter int AW = 5,
  parameter int CW = 3,
  parameter int TBL_ROWS = 6,
  parameter int ROW_STRIDE = 5
) (
  input  mode_e          mode,
  input  oob_e           pol,
  input  logic [IW-1:0]  idx,
  input  logic [CW-1:0]  col,
  output logic           skip,
  output logic [AW-1:0]  addr
);
  localparam int unsigned CAP_ROW  = TBL_ROWS;
  localparam int unsigned CAP_ELEM = TBL_ROWS * ROW_STRIDE;
  localparam int unsigned STRIDE_U = ROW_STRIDE;

  function automatic int unsigned fit_index(input oob_e p, input int unsigned ix,
                                            input int unsigned cap);
    case (p)
      OOB_CLAMP: return (ix >= cap) ? cap - 1 : ix;
      OOB_WRAP:  return ix % cap;
      default:   return ix;
    endcase
  endfunction

  int unsigned cap;
  int unsigned ix;
  int unsigned slot;
  int unsigned lin;

  always_comb begin
    cap  = (mode == MODE_ROW) ? CAP_ROW : CAP_ELEM;
    ix   = 32'(idx);
    slot = fit_index(pol, ix, cap);
    skip = (pol == OOB_SKIP) && (ix >= cap);
    lin  = (mode == MODE_ROW) ? slot * STRIDE_U + 32'(col) : slot;
    addr = lin[AW-1:0];
  end
endmodule

// File: rtl/scatter_merge.sv
module scatter_merge
  import scatter_pkg::*;
#(
  parameter int DW = 16
) (
  input  atom_e          op,
  input  logic [DW-1:0]  old_val,
  input  logic [DW-1:0]  new_val,
  output logic [DW-1:0]  result
);
  function automatic logic [DW-1:0] fold(input atom_e o, input logic signed [DW-1:0] a,
                                         input logic signed [DW-1:0] b);
    case (o)
      ATOM_ADD: return a + b;
      ATOM_MAX: return (a > b) ? a : b;
      ATOM_MIN: return (a < b) ? a : b;
      default:  return b;
    endcase
  endfunction

  assign result = fold(op, old_val, new_val);
endmodule

// File: rtl/idx_scatter.sv
module idx_scatter
  import scatter_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW = 16,
  parameter int IW = 8,
  parameter int TBL_ROWS = 6,
  parameter int ROW_STRIDE = 5,
  localparam int CAP = TBL_ROWS * ROW_STRIDE,
  localparam int AW = $clog2(CAP),
  localparam int RW = $clog2(ROWS + 1),
  localparam int CW = $clog2(COLS + 1),
  localparam int NE = ROWS * COLS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic [1:0]       oob_pol,
  input  logic [1:0]       atom_op,
  input  logic [RW-1:0]    vld_rows,
  input  logic [CW-1:0]    vld_cols,
  input  logic [NE*DW-1:0] src_tile,
  input  logic [NE*IW-1:0] idx_tile,
  output logic             busy,
  output logic             done,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  input  logic [DW-1:0]    rd_data,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [DW-1:0]    wr_data
);
  st_e              state;
  logic [NE*DW-1:0] src_q;
  logic [NE*IW-1:0] idx_q;
  mode_e            mode_q;
  oob_e             oob_q;
  atom_e            atom_q;
  logic [RW-1:0]    nr_q;
  logic [CW-1:0]    nc_q;
  logic [AW-1:0]    addr_q;

  logic [RW-1:0]    row;
  logic [CW-1:0]    col;
  logic             last;
  int               lin;
  logic [IW-1:0]    cur_idx;
  logic [DW-1:0]    cur_src;
  logic             slot_skip;
  logic [AW-1:0]    slot_addr;
  logic [DW-1:0]    merged;

  // named events
  logic accept;
  logic issue_rd;
  logic store_wr;
  logic step_ev;

  assign accept   = (state == ST_IDLE) && start;
  assign issue_rd = (state == ST_ISSUE) && !slot_skip && (atom_q != ATOM_STORE);
  assign store_wr = (state == ST_ISSUE) && !slot_skip && (atom_q == ATOM_STORE);
  assign step_ev  = ((state == ST_ISSUE) && (slot_skip || atom_q == ATOM_STORE))
                  || (state == ST_MERGE);

  always_comb begin
    lin     = int'(row) * COLS + int'(col);
    cur_idx = (mode_q == MODE_ELEM) ? idx_q[lin*IW +: IW] : idx_q[int'(row)*IW +: IW];
    cur_src = src_q[lin*DW +: DW];
  end

  scatter_walk #(.ROWS(ROWS), .COLS(COLS)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(step_ev),
    .active((state == ST_ISSUE) || (state == ST_MERGE)),
    .n_rows(nr_q), .n_cols(nc_q), .row(row), .col(col), .last(last)
  );

  scatter_slot #(.IW(IW), .AW(AW), .CW(CW), .TBL_ROWS(TBL_ROWS), .ROW_STRIDE(ROW_STRIDE)) u_slot (
    .mode(mode_q), .pol(oob_q), .idx(cur_idx), .col(col), .skip(slot_skip), .addr(slot_addr)
  );

  scatter_merge #(.DW(DW)) u_merge (
    .op(atom_q), .old_val(rd_data), .new_val(cur_src), .result(merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      src_q  <= '0;
      idx_q  <= '0;
      mode_q <= MODE_ROW;
      oob_q  <= OOB_NONE;
      atom_q <= ATOM_STORE;
      nr_q   <= '0;
      nc_q   <= '0;
      addr_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_ISSUE;
          src_q  <= src_tile;
          idx_q  <= idx_tile;
          mode_q <= mode_e'(mode);
          oob_q  <= oob_e'(oob_pol);
          atom_q <= atom_e'(atom_op);
          nr_q   <= vld_rows;
          nc_q   <= vld_cols;
        end
        ST_ISSUE: begin
          if (issue_rd) begin
            addr_q <= slot_addr;
            state  <= ST_MERGE;
          end else if (last) begin
            state <= ST_DONE;
          end
        end
        ST_MERGE: state <= last ? ST_DONE : ST_ISSUE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);
  assign rd_en   = issue_rd;
  assign rd_addr = slot_addr;
  assign wr_en   = store_wr || (state == ST_MERGE);
  assign wr_addr = (state == ST_MERGE) ? addr_q : slot_addr;
  assign wr_data = (state == ST_MERGE) ? merged : cur_src;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en && !rd_en && !done); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R2
  AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(idx_q) && $stable(src_q) && $stable(atom_q)); // R2
  AST_RMW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> wr_en && (wr_addr == $past(rd_addr))); // R10
  AST_STORE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && atom_q == ATOM_STORE) |-> !rd_en); // R10
  AST_CAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && oob_q != OOB_NONE) |-> (int'(wr_addr) < CAP)); // R9
endmodule

// File: tb/tb_idx_scatter.sv
module tb_idx_scatter;
  localparam int ROWS = 4, COLS = 4, DW = 16, IW = 8, NE = 16;
  localparam int TROWS = 6, STRIDE = 5, CAP = 30, AW = 5;

  logic clk = 0, rst_n = 0, start = 0, mode = 0;
  logic [1:0] oob_pol = 0, atom_op = 0;
  logic [2:0] vld_rows = 0, vld_cols = 0;
  logic [NE*DW-1:0] src_tile = '0;
  logic [NE*IW-1:0] idx_tile = '0;
  logic busy, done, rd_en, wr_en;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;

  idx_scatter dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .oob_pol(oob_pol),
    .atom_op(atom_op), .vld_rows(vld_rows), .vld_cols(vld_cols), .src_tile(src_tile),
    .idx_tile(idx_tile), .busy(busy), .done(done), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, last_wr_cyc = -1;
  string cur_tag = "R1";
  logic signed [DW-1:0] tbl [CAP];
  logic signed [DW-1:0] gold [CAP];
  int src_a [NE];
  int idx_a [NE];
  int exp_a [$];
  int exp_d [$];

  function automatic logic signed [DW-1:0] init_val(int i);
    return DW'(i * 7 - 50);
  endfunction

  // table memory model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < CAP; i++) tbl[i] <= init_val(i);
      rd_data <= '0;
    end else begin
      if (wr_en) tbl[wr_addr] <= wr_data;
      if (rd_en) rd_data <= tbl[rd_addr];
    end
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: scoreboard consumer
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      last_wr_cyc = cyc;
      if (exp_a.size() == 0) begin
        check(0, cur_tag, "unexpected write addr", int'(wr_addr), -1);
      end else begin
        int ea, ed;
        ea = exp_a.pop_front();
        ed = exp_d.pop_front();
        check(int'(wr_addr) == ea, cur_tag, "write addr", int'(wr_addr), ea);
        check(int'($signed(wr_data)) == ed, cur_tag, "write data", int'($signed(wr_data)), ed);
      end
    end
  end

  function automatic logic signed [DW-1:0] ref_fold(int op, logic signed [DW-1:0] o,
                                                    logic signed [DW-1:0] s);
    if (op == 1) return o + s;
    if (op == 2) return (o > s) ? o : s;
    if (op == 3) return (o < s) ? o : s;
    return s;
  endfunction

  // driver: builds expected writes, then runs the operation
  task automatic run_op(string tag, int md, int oob, int op, int nr, int nc, bit poke);
    bit last_written;
    int t;
    cur_tag = tag;
    last_written = 0;
    for (int r = 0; r < nr; r++) begin
      for (int c = 0; c < nc; c++) begin
        int k, ix, cap, ad;
        bit skip;
        logic signed [DW-1:0] nv;
        k = r * COLS + c;
        ix = md ? idx_a[k] : idx_a[r];
        cap = md ? CAP : TROWS;
        skip = 0;
        if (ix >= cap) begin
          if (oob == 1) skip = 1;
          else if (oob == 2) ix = cap - 1;
          else if (oob == 3) ix = ix % cap;
        end
        last_written = !skip;
        if (!skip) begin
          ad = md ? ix : ix * STRIDE + c;
          nv = ref_fold(op, gold[ad], DW'(src_a[k]));
          gold[ad] = nv;
          exp_a.push_back(ad);
          exp_d.push_back(int'(nv));
        end
      end
    end
    @(negedge clk);
    for (int k = 0; k < NE; k++) begin
      src_tile[k*DW +: DW] = DW'(src_a[k]);
      idx_tile[k*IW +: IW] = IW'(idx_a[k]);
    end
    mode = md[0]; oob_pol = 2'(oob); atom_op = 2'(op);
    vld_rows = 3'(nr); vld_cols = 3'(nc);
    start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (2) @(negedge clk);
      idx_tile = '1; src_tile = '0; atom_op = 2'd1; start = 1;
      @(negedge clk);
      start = 0;
    end
    t = 0;
    while (!done && t < 400) begin
      @(negedge clk);
      t++;
    end
    check(t < 400, tag, "done seen before timeout", t, 0);
    if (t < 400 && last_written)
      check(cyc == last_wr_cyc + 1, tag, "done one cycle after last write", cyc, last_wr_cyc + 1);
    check(exp_a.size() == 0, tag, "pending expected writes at done", exp_a.size(), 0);
    exp_a.delete(); exp_d.delete();
    @(negedge clk);
    check(!done && !busy, tag, "done single pulse then idle", int'({done, busy}), 0);
    begin
      int bad;
      bad = -1;
      for (int i = 0; i < CAP; i++) if (tbl[i] !== gold[i] && bad < 0) bad = i;
      check(bad < 0, tag, "table contents (first bad slot value)",
            bad < 0 ? 0 : int'(tbl[bad]), bad < 0 ? 0 : int'(gold[bad]));
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < CAP; i++) gold[i] = init_val(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !wr_en && !rd_en, "R1", "outputs after reset",
          int'({busy, done, wr_en, rd_en}), 0);

    // R3 row store
    for (int k = 0; k < NE; k++) src_a[k] = 100 + k;
    idx_a[0] = 2; idx_a[1] = 0; idx_a[2] = 5; idx_a[3] = 3;
    run_op("R3", 0, 0, 0, 4, 4, 0);

    // R4 R5 element store with duplicate slots, later wins
    for (int k = 0; k < NE; k++) begin src_a[k] = -k * 11; idx_a[k] = (k * 3) % 8; end
    run_op("R4_R5", 1, 0, 0, 4, 4, 0);

    // R6 row skip; index 6 equals row capacity (R9)
    for (int k = 0; k < NE; k++) src_a[k] = 200 + k;
    idx_a[0] = 1; idx_a[1] = 9; idx_a[2] = 7; idx_a[3] = 6;
    run_op("R6", 0, 1, 0, 4, 4, 0);

    // R7 row clamp
    for (int k = 0; k < NE; k++) src_a[k] = 300 - k;
    idx_a[0] = 200; idx_a[1] = 6; idx_a[2] = 0; idx_a[3] = 5;
    run_op("R7", 0, 2, 0, 4, 4, 0);

    // R8 element wrap
    for (int k = 0; k < NE; k++) begin src_a[k] = 400 + k; idx_a[k] = 30 + k * 2; end
    run_op("R8", 1, 3, 0, 4, 4, 0);

    // R9 element capacity: 29 writes, 30 and up dropped
    for (int k = 0; k < NE; k++) begin src_a[k] = 500 + k; idx_a[k] = 20 + k; end
    run_op("R9", 1, 1, 0, 4, 4, 0);

    // R10 element add accumulate
    for (int k = 0; k < NE; k++) begin src_a[k] = k - 5; idx_a[k] = k % 3; end
    run_op("R10", 1, 0, 1, 4, 4, 0);

    // R11 row max, mixed signs
    for (int k = 0; k < NE; k++) src_a[k] = (k % 2) ? -1000 + k : 60 - k * 9;
    idx_a[0] = 4; idx_a[1] = 4; idx_a[2] = 1; idx_a[3] = 1;
    run_op("R11", 0, 0, 2, 4, 4, 0);

    // R11 element min, mixed signs
    for (int k = 0; k < NE; k++) begin
      src_a[k] = (k % 2) ? -300 - k : 50 + k;
      idx_a[k] = k % 4 + 10;
    end
    run_op("R11", 1, 0, 3, 4, 4, 0);

    // R12 single element, then partial row extent
    src_a[0] = -7; idx_a[0] = 17;
    run_op("R12", 1, 0, 0, 1, 1, 0);
    for (int k = 0; k < NE; k++) src_a[k] = 700 + k;
    idx_a[0] = 3; idx_a[1] = 1;
    run_op("R12", 0, 0, 1, 2, 3, 0);

    // R13 no remap, in-range indices
    for (int k = 0; k < NE; k++) begin src_a[k] = 800 + k; idx_a[k] = 29 - k; end
    run_op("R13", 1, 0, 0, 4, 4, 0);
    idx_a[0] = 0; idx_a[1] = 1; idx_a[2] = 2; idx_a[3] = 3;
    run_op("R13", 0, 0, 0, 4, 4, 0);

    // R2 start while busy ignored
    for (int k = 0; k < NE; k++) src_a[k] = 900 + k;
    idx_a[0] = 5; idx_a[1] = 4; idx_a[2] = 3; idx_a[3] = 2;
    run_op("R2", 0, 0, 0, 4, 4, 1);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule